// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block drives the address register of a microcoded control unit. On every clock edge it chooses the next control-store address from four sources: the current address plus one, a one-deep return register, an address supplied by an external instruction mapping unit, and a branch target carried in the microinstruction. The choice depends on a 2-bit sequencing operation and, for branches, on a tested condition. That condition is one of sixteen selectable status sources, and it can be inverted before it is used.

A branch microinstruction either jumps or calls, depending on a link bit. A taken call stores the address that follows the calling word into the return register. A later return operation resumes from there. The return register holds one level only, so a second call overwrites it. The control store and the mapping unit sit outside this block. The sequencer only presents the address that selects the next microinstruction.

Top module: `useq_core`

## Requirements
- R1: An active-low asynchronous reset forces `car` to 0 and clears the return register. A return issued straight after reset therefore yields address 0.
- R2: With `seq_op` = 2'b00 the next `car` is `car`+1, wrapping from the largest address to 0.
- R3: With `seq_op` = 2'b01 the next `car` is the value held in the return register.
- R4: With `seq_op` = 2'b10 the next `car` is `map_addr`.
- R5: With `seq_op` = 2'b11 and `link_en` = 0, the next `car` is `branch_target` if the tested condition is true, and `car`+1 otherwise. The return register is not changed.
- R6: With `seq_op` = 2'b11 and `link_en` = 1, a true condition loads `branch_target` into `car` and stores `car`+1 (wrapping) into the return register. A false condition only increments `car`.
- R7: The tested condition is the selected source when `cond_invert` = 0, and its complement when `cond_invert` = 1.
- R8: `cond_sel` picks the source as follows: 0 gives constant 1; 1 to 5 give `arch_flags[0]` to `arch_flags[4]` (zero, negative, carry, overflow, interrupt-enable); 6 to 9 give `micro_flags[0]` to `micro_flags[3]` (zero, negative, carry, overflow); 10 gives `irq`.
- R9: `cond_sel` values 11 to 15 select constant 0, whatever the flags and `irq` are.
- R10: The return register changes only on a taken call. Increments, returns, map loads, jumps and untaken calls leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_op | input | 2 | Sequencing operation: 00 increment, 01 return, 10 map, 11 branch |
| link_en | input | 1 | In a branch, 1 makes it a call |
| cond_invert | input | 1 | Complements the selected condition |
| cond_sel | input | 4 | Condition source select |
| branch_target | input | 8 | Target address of a branch or call |
| map_addr | input | 8 | Address from the instruction mapping unit |
| arch_flags | input | 5 | Zero, negative, carry, overflow, interrupt-enable (bit 0 to bit 4) |
| micro_flags | input | 4 | Microcode zero, negative, carry, overflow (bit 0 to bit 3) |
| irq | input | 1 | Interrupt request |
| car | output | 8 | Control address register |

## Verification
The bench uses the default parameters: an 8-bit address and a 4-bit condition select. With an 8-bit address, one map load reaches address 255. That makes wrap-around on increment, and on the saved call-return address, reachable in a couple of cycles. With a 4-bit select, the bench can walk all sixteen codes. For every live source it drives the flag alone high and alone low. It also checks that the five unused codes stay false with every flag raised.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_INC = 2'b00,
    SEQ_RET = 2'b01,
    SEQ_MAP = 2'b10,
    SEQ_BR  = 2'b11
  } seq_op_e;

  localparam int unsigned ARCH_FLAG_W  = 5;
  localparam int unsigned MICRO_FLAG_W = 4;

  // Condition select code layout
  localparam int unsigned SEL_CONST1   = 0;
  localparam int unsigned SEL_ARCH_LO  = 1;
  localparam int unsigned SEL_MICRO_LO = SEL_ARCH_LO + ARCH_FLAG_W;
  localparam int unsigned SEL_IRQ      = SEL_MICRO_LO + MICRO_FLAG_W;

endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic                    invert,
  input  logic [ARCH_FLAG_W-1:0]  arch_flags,
  input  logic [MICRO_FLAG_W-1:0] micro_flags,
  input  logic                    irq,
  output logic                    cond_true
);

  localparam int unsigned NSRC = 2 ** SEL_W;

  logic [NSRC-1:0] src;

  // One source per select code; codes past the interrupt line read as 0.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SEL_CONST1) begin : g_one
      assign src[i] = 1'b1;
    end else if (i < SEL_MICRO_LO) begin : g_arch
      assign src[i] = arch_flags[i-SEL_ARCH_LO];
    end else if (i < SEL_IRQ) begin : g_micro
      assign src[i] = micro_flags[i-SEL_MICRO_LO];
    end else if (i == SEL_IRQ) begin : g_irq
      assign src[i] = irq;
    end else begin : g_zero
      assign src[i] = 1'b0;
    end
  end

  assign cond_true = src[sel] ^ invert;

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  seq_op_e           op,
  input  logic              link,
  input  logic              cond,
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] ret,
  output logic [ADDR_W-1:0] car_nxt,
  output logic              ret_we,
  output logic [ADDR_W-1:0] ret_nxt
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] car_inc;

  assign car_inc = car + ADDR_ONE;
  assign ret_nxt = car_inc;

  always_comb begin
    car_nxt = car_inc;
    ret_we  = 1'b0;
    case (op)
      SEQ_INC: car_nxt = car_inc;
      SEQ_RET: car_nxt = ret;
      SEQ_MAP: car_nxt = map_addr;
      SEQ_BR: begin
        if (cond) begin
          car_nxt = target;
          ret_we  = link;
        end
      end
      default: car_nxt = car_inc;
    endcase
  end

endmodule

// File: rtl/useq_ret_reg.sv
module useq_ret_reg #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  logic [ADDR_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R10: without a write enable the saved address holds
  p_ret_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> q == $past(q));

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        seq_op,
  input  logic              link_en,
  input  logic              cond_invert,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [ADDR_W-1:0] branch_target,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [4:0]        arch_flags,
  input  logic [3:0]        micro_flags,
  input  logic              irq,
  output logic [ADDR_W-1:0] car
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  seq_op_e           op;
  logic              cond;
  logic [ADDR_W-1:0] car_q;
  logic [ADDR_W-1:0] car_nxt;
  logic              ret_we;
  logic [ADDR_W-1:0] ret_d;
  logic [ADDR_W-1:0] ret_q;

  assign op  = seq_op_e'(seq_op);
  assign car = car_q;

  useq_cond_sel #(.SEL_W(SEL_W)) u_cond (
    .sel         (cond_sel),
    .invert      (cond_invert),
    .arch_flags  (arch_flags),
    .micro_flags (micro_flags),
    .irq         (irq),
    .cond_true   (cond)
  );

  useq_next_sel #(.ADDR_W(ADDR_W)) u_next (
    .op       (op),
    .link     (link_en),
    .cond     (cond),
    .car      (car_q),
    .map_addr (map_addr),
    .target   (branch_target),
    .ret      (ret_q),
    .car_nxt  (car_nxt),
    .ret_we   (ret_we),
    .ret_nxt  (ret_d)
  );

  useq_ret_reg #(.ADDR_W(ADDR_W)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ret_we),
    .d     (ret_d),
    .q     (ret_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= car_nxt;
  end

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_op == 2'b00 |=> car_q == $past(car_q) + ADDR_ONE);

  p_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_op == 2'b01 |=> car_q == $past(ret_q));

  p_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_op == 2'b10 |=> car_q == $past(map_addr));

  p_jump_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op == 2'b11 && !link_en) |=> ret_q == $past(ret_q));

  p_call_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op == 2'b11 && link_en && cond) |=>
      (ret_q == $past(car_q) + ADDR_ONE) && (car_q == $past(branch_target)));

  p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op == 2'b11 && cond_sel == '0 && cond_invert) |=>
      car_q == $past(car_q) + ADDR_ONE);

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op == 2'b11 && cond_sel == SEL_W'(1) && (arch_flags[0] ^ cond_invert)) |=>
      car_q == $past(branch_target));

  p_unused_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op == 2'b11 && cond_sel >= SEL_W'(11) && !cond_invert) |=>
      car_q == $past(car_q) + ADDR_ONE);

endmodule

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] seq_op;
  logic       link_en;
  logic       cond_invert;
  logic [3:0] cond_sel;
  logic [7:0] branch_target;
  logic [7:0] map_addr;
  logic [4:0] arch_flags;
  logic [3:0] micro_flags;
  logic       irq;
  logic [7:0] car;

  int n_chk;
  int n_bad;
  bit done;

  useq_core u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .seq_op        (seq_op),
    .link_en       (link_en),
    .cond_invert   (cond_invert),
    .cond_sel      (cond_sel),
    .branch_target (branch_target),
    .map_addr      (map_addr),
    .arch_flags    (arch_flags),
    .micro_flags   (micro_flags),
    .irq           (irq),
    .car           (car)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one microinstruction, then sample 1 ns after the edge
  task automatic step(logic [1:0] op, logic lk, logic inv, logic [3:0] sel,
                      logic [7:0] tgt, logic [7:0] mp);
    seq_op = op; link_en = lk; cond_invert = inv; cond_sel = sel;
    branch_target = tgt; map_addr = mp;
    @(posedge clk);
    #1;
  endtask

  task automatic go_to(logic [7:0] a);
    step(2'b10, 1'b0, 1'b0, 4'd0, 8'h00, a);
  endtask

  // all sources set to ~v, the one at code k set to v
  task automatic set_flags(int k, logic v);
    arch_flags  = v ? 5'b00000 : 5'b11111;
    micro_flags = v ? 4'b0000  : 4'b1111;
    irq         = ~v;
    if (k >= 1 && k <= 5) arch_flags[k-1] = v;
    if (k >= 6 && k <= 9) micro_flags[k-6] = v;
    if (k == 10) irq = v;
  endtask

  task automatic t_reset;
    chk("R1", car, 8'h00);
    step(2'b01, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R1", car, 8'h00);
    go_to(8'h33);
    step(2'b11, 1'b1, 1'b0, 4'd0, 8'h70, 8'h00);
    chk("R6", car, 8'h70);
    #1 rst_n = 1'b0;
    #1;
    chk("R1", car, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b01, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R1", car, 8'h00);
  endtask

  task automatic t_inc_map;
    go_to(8'h5A);
    chk("R4", car, 8'h5A);
    go_to(8'hFE);
    chk("R4", car, 8'hFE);
    step(2'b00, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R2", car, 8'hFF);
    step(2'b00, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R2", car, 8'h00);
  endtask

  task automatic t_jump_call;
    go_to(8'h20);
    step(2'b11, 1'b1, 1'b0, 4'd0, 8'h60, 8'h00);
    chk("R6", car, 8'h60);
    step(2'b00, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R2", car, 8'h61);
    go_to(8'h30);
    step(2'b11, 1'b1, 1'b1, 4'd0, 8'h90, 8'h00);
    chk("R7", car, 8'h31);
    step(2'b11, 1'b0, 1'b0, 4'd0, 8'h80, 8'h00);
    chk("R5", car, 8'h80);
    step(2'b11, 1'b0, 1'b1, 4'd0, 8'h10, 8'h00);
    chk("R5", car, 8'h81);
    step(2'b01, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R10", car, 8'h21);
    step(2'b01, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R3", car, 8'h21);
    go_to(8'hFF);
    step(2'b11, 1'b1, 1'b0, 4'd0, 8'h05, 8'h00);
    chk("R6", car, 8'h05);
    step(2'b01, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00);
    chk("R6", car, 8'h00);
  endtask

  task automatic t_sources;
    for (int k = 1; k <= 10; k++) begin
      go_to(8'h90);
      set_flags(k, 1'b1);
      step(2'b11, 1'b0, 1'b0, 4'(k), 8'h40, 8'h00);
      chk("R8", car, 8'h40);
      go_to(8'h90);
      set_flags(k, 1'b0);
      step(2'b11, 1'b0, 1'b0, 4'(k), 8'h40, 8'h00);
      chk("R8", car, 8'h91);
    end
  endtask

  task automatic t_unused;
    arch_flags = 5'b11111; micro_flags = 4'b1111; irq = 1'b1;
    for (int k = 11; k <= 15; k++) begin
      go_to(8'hA0);
      step(2'b11, 1'b0, 1'b0, 4'(k), 8'h44, 8'h00);
      chk("R9", car, 8'hA1);
      go_to(8'hA0);
      step(2'b11, 1'b0, 1'b1, 4'(k), 8'h44, 8'h00);
      chk("R7", car, 8'h44);
    end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    seq_op = 2'b00; link_en = 1'b0; cond_invert = 1'b0; cond_sel = 4'd0;
    branch_target = 8'h00; map_addr = 8'h00;
    arch_flags = 5'b0; micro_flags = 4'b0; irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inc_map();
    t_jump_call();
    t_sources();
    t_unused();
    done = 1'b1;
    finish_run();
  end

endmodule